// File: doc/BRIEF.md
# Fault Pulse Width Qualifier

This block sits behind a pair of window comparators that share one active-low output line. Either comparator pulls the line low while the sensed signal is outside its band. The block samples the line on the system clock and reports a fault only when one low excursion lasts longer than a programmable minimum width. It is meant for the AC and pulsating-DC fault path of a residual-current detector. Short disturbances such as arcing spikes are filtered out, while genuine wide excursions are passed on as a single-cycle strobe to a later latching or stretching stage.

The line first passes through a two-flop synchronizer and is inverted, so a fault is active high inside the block. A leading edge starts a delay of `WIDTH_CYC` cycles, and a qualification window of the same length follows it. The strobe fires only if the pulse has stayed high without a break from its leading edge to the moment the window opens. While the delay or the window is running, further leading edges are ignored.

Top module: `pulse_width_qualifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fault_strobe` is 0. Reset loads the synchronizer with the idle (high) line level.
- R2: The line is active low. A line held at 1 never produces a strobe.
- R3: If the line is sampled low on W+1 or more consecutive rising edges (W = `WIDTH_CYC`), `fault_strobe` is 1 for exactly one cycle. It becomes visible after the (W+2)-th rising edge following the edge that first sampled the low level.
- R4: A low excursion of W or fewer consecutive samples, down to a single sample, never produces a strobe.
- R5: A low excursion produces at most one strobe, however long it lasts.
- R6: Once a leading edge has been accepted, any leading edge seen within the following 2W cycles is ignored and cannot produce a strobe.
- R7: A single high sample inside the first W+1 samples of an accepted excursion disqualifies that excursion.
- R8: `fault_strobe` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_line_n | input | 1 | Shared comparator output, active low, asynchronous |
| fault_strobe | output | 1 | One-cycle qualified-fault pulse |

## Verification
Several properties are checked on every cycle. A strobe is always single-cycle, and it is quiet right after reset. A strobe can appear only when the qualification window opens, after a continuously held pulse. An accepted leading edge always makes the timer busy. The bench is needed to show the exact W versus W+1 boundary, the fixed latency, and the one-strobe-per-excursion behaviour. It also covers the ignoring of leading edges during the busy span and the rejection of broken pulses. It does this by comparing every cycle of directed and random pulse trains against a model that works only from sample indices.

// File: rtl/pwq_pkg.sv
package pwq_pkg;

  typedef enum logic [1:0] {
    PQ_IDLE  = 2'd0,
    PQ_DELAY = 2'd1,
    PQ_WIN   = 2'd2
  } pq_state_t;

  // counter width able to hold width-1
  function automatic int unsigned pq_cnt_bits(input int unsigned width);
    return (width > 1) ? $clog2(width) : 1;
  endfunction

  // edges from first low sample to visible strobe
  function automatic int unsigned pq_latency(input int unsigned width);
    return width + 2;
  endfunction

  // cycles after an accepted edge during which new edges are ignored
  function automatic int unsigned pq_busy_span(input int unsigned width);
    return 2 * width;
  endfunction

endpackage

// File: rtl/pwq_sync.sv
module pwq_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_n,
  output logic pulse
);
  logic [1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= 2'b11;
    else     stage <= {stage[0], line_n};
  end

  assign pulse = ~stage[1];
endmodule

// File: rtl/pwq_edge.sv
module pwq_edge (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  output logic lead
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= pulse;
  end

  assign lead = pulse & ~pulse_q;
endmodule

// File: rtl/pwq_timer.sv
module pwq_timer
  import pwq_pkg::*;
#(
  parameter int unsigned WIDTH_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  input  logic lead,
  output logic start,
  output logic busy,
  output logic win_on,
  output logic held_ok,
  output logic strobe
);
  localparam int unsigned CW = pq_cnt_bits(WIDTH_CYC);
  localparam logic [CW-1:0] RELOAD = CW'(WIDTH_CYC - 1);

  pq_state_t     st;
  logic [CW-1:0] cnt;
  logic          ok_q;
  logic          str_q;
  logic          cnt_done;

  assign cnt_done = (cnt == '0);
  assign start    = (st == PQ_IDLE) && lead;
  assign busy     = (st != PQ_IDLE);
  assign win_on   = (st == PQ_WIN);
  assign held_ok  = ok_q;
  assign strobe   = str_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PQ_IDLE;
      cnt   <= '0;
      ok_q  <= 1'b0;
      str_q <= 1'b0;
    end else begin
      str_q <= 1'b0;
      case (st)
        PQ_IDLE: begin
          if (lead) begin
            st   <= PQ_DELAY;
            cnt  <= RELOAD;
            ok_q <= 1'b1;
          end
        end
        PQ_DELAY: begin
          ok_q <= ok_q & pulse;
          if (cnt_done) begin
            st    <= PQ_WIN;
            cnt   <= RELOAD;
            str_q <= ok_q & pulse;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PQ_WIN: begin
          if (cnt_done) st <= PQ_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= PQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulse_width_qualifier.sv
module pulse_width_qualifier #(
  parameter int unsigned WIDTH_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_line_n,
  output logic fault_strobe
);
  logic pulse_w;
  logic lead_w;
  logic start_w;
  logic busy_w;
  logic win_w;
  logic ok_w;

  pwq_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .line_n(cmp_line_n),
    .pulse (pulse_w)
  );

  pwq_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .pulse(pulse_w),
    .lead (lead_w)
  );

  pwq_timer #(.WIDTH_CYC(WIDTH_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .pulse  (pulse_w),
    .lead   (lead_w),
    .start  (start_w),
    .busy   (busy_w),
    .win_on (win_w),
    .held_ok(ok_w),
    .strobe (fault_strobe)
  );
endmodule

// File: rtl/pulse_width_qualifier_chk.sv
module pulse_width_qualifier_chk (
  input logic clk,
  input logic rst,
  input logic pulse,
  input logic start,
  input logic busy,
  input logic win_on,
  input logic held_ok,
  input logic strobe
);
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  // R1
  strobe_quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !strobe);

  // R3
  strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> win_on);

  // R2
  strobe_needs_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(pulse));

  // R7
  strobe_needs_held_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(held_ok));

  // R6
  start_makes_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

bind pulse_width_qualifier pulse_width_qualifier_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .pulse  (pulse_w),
  .start  (start_w),
  .busy   (busy_w),
  .win_on (win_w),
  .held_ok(ok_w),
  .strobe (fault_strobe)
);

// File: tb/pulse_width_qualifier_test.sv
`timescale 1ns/1ps
module pulse_width_qualifier_test;
  localparam int W = 20;
  localparam int N = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_n = 1'b1;
  logic strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic stim [N];
  bit   expv [N];
  int   tagv [N];
  int   fill = 0;

  always #4 clk = ~clk;

  pulse_width_qualifier #(.WIDTH_CYC(W)) uut (
    .clk         (clk),
    .rst         (rst),
    .cmp_line_n  (line_n),
    .fault_strobe(strobe)
  );

  function automatic string tag_name(input int t);
    case (t)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "random R3/R4/R6";
    endcase
  endfunction

  task automatic add_seg(input int lo, input int hi, input int t);
    for (int i = 0; i < lo && fill < N; i++) begin stim[fill] = 1'b0; tagv[fill] = t; fill++; end
    for (int i = 0; i < hi && fill < N; i++) begin stim[fill] = 1'b1; tagv[fill] = t; fill++; end
  endtask

  function automatic logic samp(input int k);
    return (k < 0) ? 1'b1 : stim[k];
  endfunction

  // expectations from sample indices only
  task automatic build_expect();
    int next_ok = 0;
    for (int n = 0; n < N; n++) expv[n] = 1'b0;
    for (int s = 0; s < N; s++) begin
      if (!samp(s - 1) && samp(s - 2) && s >= next_ok) begin
        bit held = 1'b1;
        next_ok = s + 2 * W + 1;
        for (int k = s - 1; k <= s + W - 1; k++)
          if (k >= N || samp(k)) held = 1'b0;
        if (held && s + W + 1 < N) expv[s + W + 1] = 1'b1;
      end
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: fault_strobe=%b expected %b at %0t", req, act, exp_v, $time);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    add_seg(0, 12, 1);          // idle line
    add_seg(W, 3 * W, 3);       // exactly W: rejected
    add_seg(W + 1, 3 * W, 2);   // W+1: qualifies
    for (int i = 0; i < 6; i++) add_seg(1, 5, 3);  // spikes
    add_seg(2, 3 * W, 3);
    add_seg(150, 3 * W, 4);     // very long pulse
    add_seg(W / 2, 1, 6);       // broken pulse
    add_seg(W + 5, 3 * W, 6);
    add_seg(W + 1, 2, 5);       // second pulse inside busy span
    add_seg(W + 1, 3 * W, 5);
    add_seg(W + 1, W + 1, 5);   // gap chosen so the edge lands right after busy
    add_seg(W + 1, 3 * W, 5);
    while (fill < N - 4 * W)
      add_seg(int'($urandom_range(1, 3 * W)), int'($urandom_range(1, 3 * W)), 7);
    add_seg(0, N, 7);
    build_expect();

    repeat (4) begin
      @(posedge clk); @(negedge clk);
      check("R1", strobe, 1'b0);
    end
    rst = 1'b0;
    for (int n = 0; n < N; n++) begin
      line_n = stim[n];
      @(posedge clk); @(negedge clk);
      check(tag_name(tagv[n]), strobe, expv[n]);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule